// File: doc/BRIEF.md
# Index-Register Address Generator

This block forms the effective word address of a memory-referencing instruction. It adds three things: a base register value, which may point at any word of a bank, a displacement taken from the instruction, and the offset part of a selected index register. An index register is one 36-bit word. Its lower half is an offset and its upper half is a stride. One instruction can use the offset for addressing and then post-increment it by the stride, which writes the index register back.

The same datapath also does plain whole-word addition and subtraction on an index register. These are separate operations, selected by an opcode. They produce a register write-back but no address. Every result is registered and appears on the outputs one clock after the valid strobe that requested it. The surrounding pipeline uses the address strobe to start the memory access and the write strobe to update the register file.

Top module: `idx_addr_gen`

## Requirements
- R1: After reset and before any valid request, `ea_vld_o` and `x_we_o` are both low.
- R2: One cycle after a valid request with `op_i` = 2'b00 (address), `ea_vld_o` is high and `ea_o` equals (`base_i` + `disp_i` + `idx_i[17:0]`) modulo 2^24. All terms are zero-extended.
- R3: The offset used in R2 is the value before any increment, even when post-increment is requested in the same request.
- R4: One cycle after a valid address request with `inc_en_i` high, `x_we_o` is high and `x_new_o[17:0]` equals (`idx_i[17:0]` + `idx_i[35:18]`) modulo 2^18.
- R5: Under R4, `x_new_o[35:18]` equals `idx_i[35:18]`, so the stride is left unchanged.
- R6: One cycle after a valid address request with `inc_en_i` low, `x_we_o` is low.
- R7: One cycle after a valid request with `op_i` = 2'b01 (add), `x_we_o` is high, `ea_vld_o` is low, and `x_new_o` equals (`idx_i` + `opnd_i`) modulo 2^36. `inc_en_i` has no effect.
- R8: One cycle after a valid request with `op_i` = 2'b10 (subtract), `x_we_o` is high, `ea_vld_o` is low, and `x_new_o` equals (`idx_i` − `opnd_i`) modulo 2^36.
- R9: In the cycle after a clock edge with `valid_i` low, or with `op_i` = 2'b11 (reserved), both strobes are low and `ea_o` and `x_new_o` hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Request strobe |
| op_i | input | 2 | 00 address, 01 add, 10 subtract, 11 reserved |
| inc_en_i | input | 1 | Post-increment the index register on an address request |
| base_i | input | 24 | Base register word address |
| disp_i | input | 16 | Instruction displacement |
| idx_i | input | 36 | Index register: stride [35:18], offset [17:0] |
| opnd_i | input | 36 | Operand for whole-word add or subtract |
| ea_o | output | 24 | Effective address |
| ea_vld_o | output | 1 | Effective address valid |
| x_new_o | output | 36 | Updated index register value |
| x_we_o | output | 1 | Index register write enable |

## Verification
Every result of this block, whether the address, the updated index word or either strobe, is due exactly one clock edge after the request is applied. The bench drives each request on a falling edge and samples all outputs on the next falling edge, so it reads once the single register stage has loaded. Hold behaviour is checked by issuing an idle or reserved request after a known result and sampling one falling edge later. The checker compares each strobe against the inputs captured one edge earlier.

// File: rtl/idxag_pkg.sv
package idxag_pkg;
  typedef enum logic [1:0] {
    OP_ADDR = 2'b00,
    OP_ADD  = 2'b01,
    OP_SUB  = 2'b10,
    OP_NONE = 2'b11
  } idx_op_e;
endpackage

// File: rtl/idxag_ea_adder.sv
module idxag_ea_adder #(
  parameter int ADDR_W = 24,
  parameter int DISP_W = 16,
  parameter int OFS_W  = 18
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [OFS_W-1:0]  ofs_i,
  output logic [ADDR_W-1:0] ea_o
);
  localparam int SUM_W = ADDR_W + 2;

  logic [SUM_W-1:0] sum;

  always_comb begin
    sum  = SUM_W'(base_i) + SUM_W'(disp_i) + SUM_W'(ofs_i);
    ea_o = sum[ADDR_W-1:0];
  end
endmodule

// File: rtl/idxag_idx_update.sv
module idxag_idx_update
  import idxag_pkg::*;
#(
  parameter int WORD_W = 36,
  parameter int OFS_W  = 18
) (
  input  idx_op_e           op_i,
  input  logic [WORD_W-1:0] idx_i,
  input  logic [WORD_W-1:0] opnd_i,
  output logic [WORD_W-1:0] x_new_o
);
  localparam int STR_W = WORD_W - OFS_W;

  logic [OFS_W-1:0] stride_ext;
  logic [OFS_W-1:0] ofs_next;

  generate
    if (STR_W >= OFS_W) begin : g_str_wide
      assign stride_ext = idx_i[OFS_W +: OFS_W];
    end else begin : g_str_narrow
      assign stride_ext = {{(OFS_W-STR_W){1'b0}}, idx_i[WORD_W-1:OFS_W]};
    end
  endgenerate

  always_comb begin
    ofs_next = idx_i[OFS_W-1:0] + stride_ext;
    unique case (op_i)
      OP_ADD:  x_new_o = idx_i + opnd_i;
      OP_SUB:  x_new_o = idx_i - opnd_i;
      default: x_new_o = {idx_i[WORD_W-1:OFS_W], ofs_next};
    endcase
  end
endmodule

// File: rtl/idx_addr_gen.sv
module idx_addr_gen
  import idxag_pkg::*;
#(
  parameter int WORD_W = 36,
  parameter int OFS_W  = 18,
  parameter int ADDR_W = 24,
  parameter int DISP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [1:0]        op_i,
  input  logic              inc_en_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [WORD_W-1:0] idx_i,
  input  logic [WORD_W-1:0] opnd_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic              ea_vld_o,
  output logic [WORD_W-1:0] x_new_o,
  output logic              x_we_o
);
  idx_op_e           op;
  logic [ADDR_W-1:0] ea_calc;
  logic [WORD_W-1:0] x_calc;
  logic              ea_vld_d;
  logic              x_we_d;
  logic              ea_en;
  logic              x_en;
  logic [ADDR_W-1:0] ea_q;
  logic [WORD_W-1:0] x_q;
  logic              ea_vld_q;
  logic              x_we_q;

  assign op = idx_op_e'(op_i);

  idxag_ea_adder #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .OFS_W(OFS_W)) u_ea (
    .base_i (base_i),
    .disp_i (disp_i),
    .ofs_i  (idx_i[OFS_W-1:0]),
    .ea_o   (ea_calc)
  );

  idxag_idx_update #(.WORD_W(WORD_W), .OFS_W(OFS_W)) u_upd (
    .op_i    (op),
    .idx_i   (idx_i),
    .opnd_i  (opnd_i),
    .x_new_o (x_calc)
  );

  // next-state decode
  always_comb begin
    ea_vld_d = 1'b0;
    x_we_d   = 1'b0;
    if (valid_i) begin
      unique case (op)
        OP_ADDR: begin
          ea_vld_d = 1'b1;
          x_we_d   = inc_en_i;
        end
        OP_ADD, OP_SUB: x_we_d = 1'b1;
        default: ;
      endcase
    end
    ea_en = ea_vld_d;
    x_en  = x_we_d;
  end

  // strobe registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_vld_q <= 1'b0;
      x_we_q   <= 1'b0;
    end else begin
      ea_vld_q <= ea_vld_d;
      x_we_q   <= x_we_d;
    end
  end

  // data registers with clock enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_q <= '0;
    end else if (ea_en) begin
      ea_q <= ea_calc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
    end else if (x_en) begin
      x_q <= x_calc;
    end
  end

  assign ea_o     = ea_q;
  assign ea_vld_o = ea_vld_q;
  assign x_new_o  = x_q;
  assign x_we_o   = x_we_q;
endmodule

// File: rtl/idx_addr_gen_chk.sv
module idx_addr_gen_chk #(
  parameter int WORD_W = 36,
  parameter int OFS_W  = 18,
  parameter int ADDR_W = 24,
  parameter int DISP_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              valid_i,
  input logic [1:0]        op_i,
  input logic              inc_en_i,
  input logic [ADDR_W-1:0] base_i,
  input logic [DISP_W-1:0] disp_i,
  input logic [WORD_W-1:0] idx_i,
  input logic [WORD_W-1:0] opnd_i,
  input logic [ADDR_W-1:0] ea_o,
  input logic              ea_vld_o,
  input logic [WORD_W-1:0] x_new_o,
  input logic              x_we_o
);
  // R2 R3
  ea_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ea_vld_o |-> ea_o == ADDR_W'(ADDR_W'($past(base_i)) + ADDR_W'($past(disp_i))
                                 + ADDR_W'($past(idx_i[OFS_W-1:0]))));

  // R4
  post_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (x_we_o && ea_vld_o) |-> x_new_o[OFS_W-1:0] ==
      OFS_W'($past(idx_i[OFS_W-1:0]) + $past(idx_i[WORD_W-1:OFS_W])));

  // R5
  stride_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (x_we_o && ea_vld_o) |-> x_new_o[WORD_W-1:OFS_W] == $past(idx_i[WORD_W-1:OFS_W]));

  // R6
  no_inc_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 2'b00 && !inc_en_i) |=> !x_we_o);

  // R7
  add_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 2'b01) |=> (x_we_o && !ea_vld_o && x_new_o == $past(idx_i) + $past(opnd_i)));

  // R8
  sub_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 2'b10) |=> (x_we_o && !ea_vld_o && x_new_o == $past(idx_i) - $past(opnd_i)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_i || op_i == 2'b11) |=> (!ea_vld_o && !x_we_o && $stable(ea_o) && $stable(x_new_o)));
endmodule

bind idx_addr_gen idx_addr_gen_chk #(
  .WORD_W(WORD_W), .OFS_W(OFS_W), .ADDR_W(ADDR_W), .DISP_W(DISP_W)
) u_chk (.*);

// File: tb/tb_idx_addr_gen.sv
module tb_idx_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic        inc_en_i = 1'b0;
  logic [23:0] base_i = '0;
  logic [15:0] disp_i = '0;
  logic [35:0] idx_i = '0;
  logic [35:0] opnd_i = '0;
  logic [23:0] ea_o;
  logic        ea_vld_o;
  logic [35:0] x_new_o;
  logic        x_we_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  idx_addr_gen dut (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drives on a falling edge, samples at the next falling edge
  task automatic issue(input logic v, input logic [1:0] op, input logic inc,
                       input logic [23:0] b, input logic [15:0] d,
                       input logic [35:0] x, input logic [35:0] o);
    valid_i = v; op_i = op; inc_en_i = inc;
    base_i = b; disp_i = d; idx_i = x; opnd_i = o;
    @(negedge clk);
  endtask

  task automatic addr_case(input logic [23:0] b, input logic [15:0] d,
                           input logic [17:0] ofs, input logic [17:0] str, input logic inc);
    logic [23:0] exp_ea;
    logic [17:0] exp_ofs;
    exp_ea  = 24'((32'(b) + 32'(d) + 32'(ofs)) & 32'hFF_FFFF);
    exp_ofs = 18'((32'(ofs) + 32'(str)) % 32'h4_0000);
    issue(1'b1, 2'b00, inc, b, d, {str, ofs}, 36'h0);
    check("R2 ea_vld", 64'(ea_vld_o), 64'd1);
    check("R2 R3 ea", 64'(ea_o), 64'(exp_ea));
    if (inc) begin
      check("R4 we", 64'(x_we_o), 64'd1);
      check("R4 offset", 64'(x_new_o[17:0]), 64'(exp_ofs));
      check("R5 stride", 64'(x_new_o[35:18]), 64'(str));
    end else begin
      check("R6 we low", 64'(x_we_o), 64'd0);
    end
  endtask

  initial begin
    logic [17:0] ofs_set [5];
    logic [17:0] str_set [4];
    logic [23:0] base_set [4];
    logic [15:0] disp_set [3];
    logic [23:0] last_ea;
    logic [35:0] last_x;
    ofs_set  = '{18'h0, 18'h1, 18'h2_0000, 18'h3_FFFF, 18'h3_FFFE};
    str_set  = '{18'h0, 18'h1, 18'h2_0000, 18'h3_FFFF};
    base_set = '{24'h0, 24'h00_1234, 24'hFF_FFFF, 24'hFF_0000};
    disp_set = '{16'h0, 16'h0001, 16'hFFFF};

    @(negedge clk);
    @(negedge clk);
    check("R1 ea_vld reset", 64'(ea_vld_o), 64'd0);
    check("R1 we reset", 64'(x_we_o), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ea_vld idle", 64'(ea_vld_o), 64'd0);
    check("R1 we idle", 64'(x_we_o), 64'd0);

    // R2..R6 sweep over field corners
    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 4; j++)
        for (int k = 0; k < 2; k++)
          addr_case(24'h00_0100, 16'h0010, ofs_set[i], str_set[j], k[0]);
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 3; j++)
        for (int k = 0; k < 5; k++)
          addr_case(base_set[i], disp_set[j], ofs_set[k], 18'h0_0005, 1'b1);

    // R7 R8 whole-word arithmetic, inc_en has no effect
    for (int i = 0; i < 24; i++) begin
      logic [35:0] a;
      logic [35:0] o;
      a = 36'(64'(i) * 64'h0_A5A5_A5A5 + 64'hF_FFFF_FFF0);
      o = 36'(64'(i) * 64'h0_3C3C_3C3D + 64'(i % 3));
      issue(1'b1, 2'b01, i[0], 24'h1, 16'h1, a, o);
      check("R7 we", 64'(x_we_o), 64'd1);
      check("R7 no ea", 64'(ea_vld_o), 64'd0);
      check("R7 sum", 64'(x_new_o), 64'((65'(a) + 65'(o)) & 65'hF_FFFF_FFFF));
      issue(1'b1, 2'b10, i[1], 24'h1, 16'h1, a, o);
      check("R8 we", 64'(x_we_o), 64'd1);
      check("R8 no ea", 64'(ea_vld_o), 64'd0);
      check("R8 diff", 64'(x_new_o), 64'(36'(a - o)));
    end

    // R9 idle and reserved opcode hold outputs
    addr_case(24'h12_3456, 16'h0042, 18'h0_0100, 18'h0_0004, 1'b1);
    last_ea = ea_o;
    last_x  = x_new_o;
    issue(1'b0, 2'b01, 1'b1, 24'hAB_CDEF, 16'h1111, 36'h1_2345_6789, 36'h5);
    check("R9 idle ea_vld", 64'(ea_vld_o), 64'd0);
    check("R9 idle we", 64'(x_we_o), 64'd0);
    check("R9 idle ea hold", 64'(ea_o), 64'(last_ea));
    check("R9 idle x hold", 64'(x_new_o), 64'(last_x));
    issue(1'b1, 2'b11, 1'b1, 24'hAB_CDEF, 16'h1111, 36'h1_2345_6789, 36'h5);
    check("R9 rsvd ea_vld", 64'(ea_vld_o), 64'd0);
    check("R9 rsvd we", 64'(x_we_o), 64'd0);
    check("R9 rsvd ea hold", 64'(ea_o), 64'(last_ea));
    check("R9 rsvd x hold", 64'(x_new_o), 64'(last_x));
    issue(1'b0, 2'b00, 1'b0, '0, '0, '0, '0);

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule